// File: doc/BRIEF.md
# Four-port GPIO pad controller with edge interrupts

This block manages a set of general-purpose I/O ports, eight pins each by default, through one shared configuration register that gives every port a two-bit mode code. For each pin it drives three pad-control signals: an output enable, an output level and a pull-up enable. Their values follow from the port's mode, the pin's data bit and the pin's mask bit. Software reaches the data, mask, pending and configuration registers through a single-cycle write/read register port.

Each pad input passes through a two-flop synchronizer. An edge detector compares the synchronized level with the level one cycle earlier. In the modes that allow interrupts, the port mode fixes the edge direction. When a masked-in pin sees an edge of that direction, it sets a sticky pending flag. The interrupt line is high while any pending flag is set. The push-pull mode never raises a flag. In that mode the mask bits choose each pin's direction instead.

Top module: `gpio_cfg_ctrl`

## Requirements
- R1: The register address is {sel[1:0], port[1:0]}. sel 00 selects the port's data register, 01 its mask register, 10 its pending flags and 11 the configuration register, for which the port field is ignored. Each register reads back what was written. Port p's mode is configuration bits [2p+1:2p].
- R2: Mode 11 (pull-up mode): a pin with data 1 has pad_pu=1 and pad_oe=0. A pin with data 0 has pad_oe=1, pad_out=0 and pad_pu=0. Interrupts fire on falling edges.
- R3: Mode 10 (push-pull mode): a pin with mask 0 has pad_oe=1, pad_out equal to its data bit and pad_pu=0. A pin with mask 1 is open-drain: pad_oe is the inverse of its data bit, pad_out=0 and pad_pu=0.
- R4: Mode 01 is open-drain, and interrupts fire on falling edges.
- R5: Mode 00 is open-drain, and interrupts fire on rising edges. An open-drain pin has pad_oe equal to the inverse of its data bit, with pad_out=0 and pad_pu=0.
- R6: pad_oe=1 together with pad_out=1 occurs only in mode 10, and pad_pu=1 occurs only while pad_oe=0.
- R7: Reset clears the configuration, data, mask and pending registers to zero. After reset every pin has pad_oe=1, pad_out=0 and pad_pu=0, and irq is 0.
- R8: A port in mode 10 sets no pending flag, whatever its mask bits are.
- R9: A qualifying edge on a pin with mask 1 sets that pin's pending flag after the third rising clock edge following the pad change, and not earlier. A pin with mask 0 never sets its flag.
- R10: A pending flag stays set until a 1 is written to its bit. Writing 0 to a pending bit leaves it unchanged. irq is the OR of all pending flags.
- R11: A configuration write changes the pad-control outputs in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | {sel, port} register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Raw pad levels, port p at bits [8p+7:8p] |
| pad_oe | output | 32 | Pad driver enable |
| pad_out | output | 32 | Pad driven level |
| pad_pu | output | 32 | Pad pull-up enable |
| irq | output | 1 | Interrupt request |

## Verification
The pad outputs are decoded without registers from the mode, data and mask state. A wrong configuration or data bit therefore shows on pad_oe, pad_out or pad_pu in the very next cycle, and the bench compares all three vectors against an arithmetic model over every mode on every port. A fault in the synchronizer or the edge history moves the pending flag off its third-edge slot or sets it on the wrong edge direction. The bench reads the pending flags and irq both one cycle early and exactly on time. A flag that is stuck or clears wrongly stays visible on irq until software writes 1 to it.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    typedef enum logic [1:0] {
        MODE_OD_RISE = 2'b00,
        MODE_OD_FALL = 2'b01,
        MODE_PUSH    = 2'b10,
        MODE_PULLUP  = 2'b11
    } port_mode_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'b00,
        SEL_MASK = 2'b01,
        SEL_PEND = 2'b10,
        SEL_CFG  = 2'b11
    } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_now,
    output logic [W-1:0] pin_was
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] now;
        logic [W-1:0] was;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = pin_raw;
        s_d.now  = s_q.meta;
        s_d.was  = s_q.now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_now = s_q.now;
    assign pin_was = s_q.was;

endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
    import gpio_cfg_pkg::*;
#(
    parameter int W = 8
) (
    input  port_mode_e   mode,
    input  logic [W-1:0] data,
    input  logic [W-1:0] mask,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] pu,
    output logic         irq_en,
    output logic         fall_sel
);

    always_comb begin
        oe       = ~data;
        out      = '0;
        pu       = '0;
        irq_en   = 1'b1;
        fall_sel = 1'b0;
        case (mode)
            MODE_PUSH: begin
                // mask 0: push-pull output; mask 1: open-drain pin
                oe     = ~mask | ~data;
                out    = data & ~mask;
                irq_en = 1'b0;
            end
            MODE_PULLUP: begin
                pu       = data;
                fall_sel = 1'b1;
            end
            MODE_OD_FALL: fall_sel = 1'b1;
            default: fall_sel = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] pin_now,
    input  logic [W-1:0] pin_was,
    input  logic [W-1:0] mask,
    input  logic         irq_en,
    input  logic         fall_sel,
    output logic [W-1:0] hit
);

    logic [W-1:0] rise, fall;

    always_comb begin
        rise = pin_now & ~pin_was;
        fall = ~pin_now & pin_was;
        hit  = (fall_sel ? fall : rise) & mask & {W{irq_en}};
    end

endmodule

// File: rtl/gpio_cfg_ctrl.sv
module gpio_cfg_ctrl
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    localparam int CFG_W    = 2 * NUM_PORTS,
    localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W   = PIDX_W + 2,
    localparam int BUS_W    = (CFG_W > PORT_W) ? CFG_W : PORT_W,
    localparam int PINS     = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_pu,
    output logic              irq
);

    typedef struct packed {
        logic [CFG_W-1:0]                   cfg;
        logic [NUM_PORTS-1:0][PORT_W-1:0]   data;
        logic [NUM_PORTS-1:0][PORT_W-1:0]   mask;
        logic [NUM_PORTS-1:0][PORT_W-1:0]   pend;
    } regs_t;

    regs_t r_d, r_q;

    logic [CFG_W-1:0]                 cfg_q;
    logic [PINS-1:0]                  pend_q;
    logic [PINS-1:0]                  sync_now, sync_was;
    logic [NUM_PORTS-1:0][PORT_W-1:0] hit;

    reg_sel_e          sel;
    logic [PIDX_W-1:0] pidx;
    logic              port_ok;

    assign cfg_q   = r_q.cfg;
    assign pend_q  = r_q.pend;
    assign sel     = reg_sel_e'(bus_addr[ADDR_W-1 -: 2]);
    assign pidx    = bus_addr[PIDX_W-1:0];
    assign port_ok = (int'(pidx) < NUM_PORTS);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic irq_en, fall_sel;

        gpio_in_sync #(.W(PORT_W)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (pad_in[p*PORT_W +: PORT_W]),
            .pin_now (sync_now[p*PORT_W +: PORT_W]),
            .pin_was (sync_was[p*PORT_W +: PORT_W])
        );

        gpio_pad_decode #(.W(PORT_W)) u_dec (
            .mode     (port_mode_e'(r_q.cfg[2*p +: 2])),
            .data     (r_q.data[p]),
            .mask     (r_q.mask[p]),
            .oe       (pad_oe[p*PORT_W +: PORT_W]),
            .out      (pad_out[p*PORT_W +: PORT_W]),
            .pu       (pad_pu[p*PORT_W +: PORT_W]),
            .irq_en   (irq_en),
            .fall_sel (fall_sel)
        );

        gpio_edge_detect #(.W(PORT_W)) u_edge (
            .pin_now  (sync_now[p*PORT_W +: PORT_W]),
            .pin_was  (sync_was[p*PORT_W +: PORT_W]),
            .mask     (r_q.mask[p]),
            .irq_en   (irq_en),
            .fall_sel (fall_sel),
            .hit      (hit[p])
        );
    end

    // Next-state: register writes, then edge hits (a hit wins over a clear)
    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            case (sel)
                SEL_DATA: if (port_ok) r_d.data[pidx] = bus_wdata[PORT_W-1:0];
                SEL_MASK: if (port_ok) r_d.mask[pidx] = bus_wdata[PORT_W-1:0];
                SEL_PEND: if (port_ok) r_d.pend[pidx] = r_q.pend[pidx] & ~bus_wdata[PORT_W-1:0];
                default:  r_d.cfg = bus_wdata[CFG_W-1:0];
            endcase
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            r_d.pend[p] = r_d.pend[p] | hit[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DATA: if (port_ok) bus_rdata[PORT_W-1:0] = r_q.data[pidx];
            SEL_MASK: if (port_ok) bus_rdata[PORT_W-1:0] = r_q.mask[pidx];
            SEL_PEND: if (port_ok) bus_rdata[PORT_W-1:0] = r_q.pend[pidx];
            default:  bus_rdata[CFG_W-1:0] = r_q.cfg;
        endcase
    end

    assign irq = |r_q.pend;

endmodule

// File: rtl/gpio_cfg_ctrl_chk.sv
module gpio_cfg_ctrl_chk #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    localparam int CFG_W    = 2 * NUM_PORTS,
    localparam int PINS     = NUM_PORTS * PORT_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CFG_W-1:0] cfg_q,
    input logic [PINS-1:0] pend_q,
    input logic [PINS-1:0] sync_now,
    input logic [PINS-1:0] sync_was,
    input logic [PINS-1:0] pad_oe,
    input logic [PINS-1:0] pad_out,
    input logic [PINS-1:0] pad_pu
);

    p_cfg_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q == '0));

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        localparam int P = i / PORT_W;

        p_pu_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pad_pu[i] |-> !pad_oe[i]);

        p_high_drive_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_oe[i] && pad_out[i]) |-> (cfg_q[2*P +: 2] == 2'b10));

        p_od_passive_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[2*P+1] == 1'b0) |-> (!pad_pu[i] && !pad_out[i]));

        p_pend_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !$past(pend_q[i])) |-> $past(sync_now[i] != sync_was[i]));

        p_push_no_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cfg_q[2*P +: 2] == 2'b10) |-> !(pend_q[i] && !$past(pend_q[i])));
    end

endmodule

bind gpio_cfg_ctrl gpio_cfg_ctrl_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_q    (cfg_q),
    .pend_q   (pend_q),
    .sync_now (sync_now),
    .sync_was (sync_was),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .pad_pu   (pad_pu)
);

// File: tb/gpio_cfg_ctrl_tb.sv
module gpio_cfg_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe, pad_out, pad_pu;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_cfg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [1:0] port, input logic [7:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = {sel, port}; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [1:0] port, output logic [7:0] v);
        @(negedge clk);
        bus_addr = {sel, port};
        #1 v = bus_rdata;
    endtask

    // returns {oe, out, pu} for one pin
    function automatic logic [2:0] pin_model(input logic [1:0] md, input logic d, input logic m);
        if (md == 2'b10 && !m) return {1'b1, d, 1'b0};
        if (md == 2'b11)       return {~d, 1'b0, d};
        return {~d, 1'b0, 1'b0};
    endfunction

    task automatic clear_all();
        for (int p = 0; p < 4; p++) wr(2'b10, 2'(p), 8'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [7:0]  cfgv;
        logic [7:0]  dv [4];
        logic [7:0]  mv [4];
        logic [31:0] e_oe, e_out, e_pu;
        logic [7:0]  exp_p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state
        rd(2'b11, 2'd0, v);  chk("R7", "cfg after reset", 32'(v), 32'h0);
        rd(2'b00, 2'd2, v);  chk("R7", "data after reset", 32'(v), 32'h0);
        rd(2'b01, 2'd1, v);  chk("R7", "mask after reset", 32'(v), 32'h0);
        chk("R7", "pad_oe after reset", pad_oe, 32'hFFFF_FFFF);
        chk("R7", "pad_out after reset", pad_out, 32'h0);
        chk("R7", "pad_pu after reset", pad_pu, 32'h0);
        chk("R7", "irq after reset", 32'(irq), 32'h0);

        // R1 register map and readback
        for (int p = 0; p < 4; p++) begin
            wr(2'b00, 2'(p), 8'h11 * (p + 3));
            wr(2'b01, 2'(p), 8'h0F ^ (8'h21 * p));
        end
        wr(2'b11, 2'd3, 8'hB4);
        for (int p = 0; p < 4; p++) begin
            rd(2'b00, 2'(p), v); chk("R1", "data readback", 32'(v), 32'(8'h11 * (p + 3)));
            rd(2'b01, 2'(p), v); chk("R1", "mask readback", 32'(v), 32'(8'h0F ^ (8'h21 * p)));
        end
        rd(2'b11, 2'd1, v); chk("R1", "cfg readback", 32'(v), 32'hB4);

        // Pad sweep: every mode on every port, two data/mask patterns
        for (int rot = 0; rot < 4; rot++) begin
            for (int pat = 0; pat < 2; pat++) begin
                for (int p = 0; p < 4; p++) begin
                    dv[p] = (pat == 1 ? 8'h5A : 8'h33) ^ 8'(p << 2);
                    mv[p] = (pat == 1 ? 8'h3C : 8'h55) ^ 8'(p);
                    cfgv[2*p +: 2] = 2'((p + rot) % 4);
                    wr(2'b00, 2'(p), dv[p]);
                    wr(2'b01, 2'(p), mv[p]);
                end
                wr(2'b11, 2'd0, cfgv);
                // sampled right after the write edge: R11
                for (int i = 0; i < 32; i++) begin
                    logic [2:0] t;
                    t = pin_model(cfgv[2*(i/8) +: 2], dv[i/8][i%8], mv[i/8][i%8]);
                    e_oe[i] = t[2]; e_out[i] = t[1]; e_pu[i] = t[0];
                end
                chk("R2/R3/R4/R5 R11", "pad_oe", pad_oe, e_oe);
                chk("R2/R3/R4/R5 R11", "pad_out", pad_out, e_out);
                chk("R2/R3/R4/R5 R11", "pad_pu", pad_pu, e_pu);
            end
        end

        // Interrupt sweep: each mode on all ports, low-nibble mask
        for (int mm = 0; mm < 4; mm++) begin
            wr(2'b11, 2'd0, {4{2'(mm)}});
            for (int p = 0; p < 4; p++) wr(2'b01, 2'(p), 8'h0F);
            clear_all();
            @(negedge clk); pad_in = '1;
            @(posedge clk); @(posedge clk); @(negedge clk);
            chk("R9", "irq one cycle early (rise)", 32'(irq), 32'h0);
            @(posedge clk); @(negedge clk);
            chk("R4/R5/R8/R9", "irq after rise", 32'(irq), 32'(mm == 0));
            exp_p = (mm == 0) ? 8'h0F : 8'h00;
            for (int p = 0; p < 4; p++) begin
                rd(2'b10, 2'(p), v); chk("R5/R8/R9", "pending after rise", 32'(v), 32'(exp_p));
            end
            clear_all();
            chk("R10", "irq after clear", 32'(irq), 32'h0);
            @(negedge clk); pad_in = '0;
            @(posedge clk); @(posedge clk); @(negedge clk);
            chk("R9", "irq one cycle early (fall)", 32'(irq), 32'h0);
            @(posedge clk); @(negedge clk);
            exp_p = (mm == 1 || mm == 3) ? 8'h0F : 8'h00;
            chk("R2/R4/R8/R9", "irq after fall", 32'(irq), 32'(exp_p != 0));
            for (int p = 0; p < 4; p++) begin
                rd(2'b10, 2'(p), v); chk("R2/R4/R8/R9", "pending after fall", 32'(v), 32'(exp_p));
            end
            clear_all();
        end

        // R8: push-pull mode with every mask bit set still raises nothing
        wr(2'b11, 2'd0, 8'hAA);
        for (int p = 0; p < 4; p++) wr(2'b01, 2'(p), 8'hFF);
        @(negedge clk); pad_in = 32'hF0F0_F0F0;
        repeat (4) @(posedge clk);
        @(negedge clk); pad_in = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R8", "irq in push-pull mode", 32'(irq), 32'h0);

        // R10: sticky flags, write-0 no effect, write-1 clears one bit
        wr(2'b11, 2'd0, 8'h00);
        clear_all();
        @(negedge clk); pad_in = '1;
        repeat (4) @(posedge clk);
        wr(2'b10, 2'd0, 8'h00);
        rd(2'b10, 2'd0, v); chk("R10", "write 0 leaves flags", 32'(v), 32'hFF);
        wr(2'b10, 2'd0, 8'h01);
        rd(2'b10, 2'd0, v); chk("R10", "write 1 clears one bit", 32'(v), 32'hFE);
        rd(2'b10, 2'd3, v); chk("R10", "other port untouched", 32'(v), 32'hFF);
        chk("R10", "irq while flags remain", 32'(irq), 32'h1);
        clear_all();
        chk("R10", "irq after full clear", 32'(irq), 32'h0);
        @(negedge clk); pad_in = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R5", "falling edge ignored in mode 00", 32'(irq), 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule